// File: doc/BRIEF.md
# Deblocking Pixel Load-Store-Pack Unit

This block carries the pixel traffic around the arithmetic of a video deblocking filter. A decoded operation arrives each cycle on a small operation port. Loads bring single bytes from a byte-wide pixel memory into a four-entry Q pixel file. Stores send bytes from a four-entry P pixel file back to memory. A pack gathers all four Q pixels into one 32-bit word and places it in either a row word file or a column word file. A move returns one P pixel.

All memory traffic uses one address pointer, held in the block. The pointer advances by a stride after every load or store. The stride is held in a configuration register. Neither loads nor stores carry it. It changes only through its own set operation, normally when filtering turns from vertical to horizontal edges, which happens a few times per macroblock.

The pipeline has two stages. The decode stage issues the memory request, takes the pack snapshot and captures the operation. The memory stage writes back returned load data and the packed word, and reads P for a move. The filter writes its P results on a separate write port. Because a move reads P in the memory stage, it can follow the filter's result with no gap. One operation is accepted every cycle and the block never stalls.

Top module: `pix_lsu_top`

## Requirements
- R1: After a synchronous active-high reset, the address pointer, the stride, all Q and P pixels, and all row and column words are zero. No memory access and no move result is presented.
- R2: A load (op_code 1) drives mem_re with mem_addr equal to the current pointer in its issue cycle. The byte returned on mem_rdata one cycle later is written into the Q entry named by op_idx.
- R3: A store (op_code 2) drives mem_we, mem_addr equal to the pointer, and mem_wdata equal to the P entry named by op_idx, all in its issue cycle. It reads P as written at earlier clock edges.
- R4: Every load and every store advances the pointer by the stride, modulo 2^16. No other operation changes the pointer, except set-address.
- R5: Set-increment (op_code 5) loads op_imm into the stride. Loads and stores never alter the stride.
- R6: Set-address (op_code 4) loads op_imm into the pointer, so the next access uses that address.
- R7: A pack (op_code 3) builds the word {Q3,Q2,Q1,Q0}, with Q0 in bits 7:0. It writes the word into entry op_idx of the column file when op_dst_col is 1 and of the row file when it is 0. The other file is left unchanged. The word can be read on the read ports from the second edge after issue.
- R8: A pack issued directly after a load sees that load's returned byte in the Q entry the load targets.
- R9: A move (op_code 6) reads P entry op_idx in the memory stage, the cycle after issue. A filter write to that entry in that same cycle is returned. move_valid and move_data appear after the second edge following issue.
- R10: Operations are accepted back to back, one per cycle, with no stall. mem_re and mem_we are never high together.
- R11: op_code 0, op_code 7, and any cycle with op_valid low do nothing: no access, no pointer change, no write.
- R12: The filter port writes p_wr_data into the P entry p_wr_idx at the edge in which p_wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation: 0 none, 1 load Q, 2 store P, 3 pack, 4 set address, 5 set increment, 6 move P |
| op_idx | input | 2 | Q, P, row or column entry index |
| op_dst_col | input | 1 | Pack destination: 1 column file, 0 row file |
| op_imm | input | 16 | Immediate for set address and set increment |
| p_wr_en | input | 1 | Filter writes a P pixel |
| p_wr_idx | input | 2 | P entry written by the filter |
| p_wr_data | input | 8 | Pixel written by the filter |
| mem_addr | output | 16 | Pixel memory address |
| mem_re | output | 1 | Pixel memory read strobe |
| mem_we | output | 1 | Pixel memory write strobe |
| mem_wdata | output | 8 | Pixel memory write data |
| mem_rdata | input | 8 | Pixel memory read data, one cycle after mem_re |
| move_valid | output | 1 | A move result is present |
| move_data | output | 8 | Moved P pixel |
| row_rd_idx | input | 2 | Row file read index |
| row_rd_data | output | 32 | Row file read data |
| col_rd_idx | input | 2 | Column file read index |
| col_rd_data | output | 32 | Column file read data |

## Verification
Some properties are checked on every cycle by the assertions:
- each access steps the pointer by exactly the stride;
- the pointer and the stride hold still when no access or set operation touches them;
- a load in decode is followed by a load write-back;
- a pack in decode is followed by exactly one file write;
- a move in the memory stage is followed by a move result;
- read and write strobes never occur together.

Other behaviour needs the bench's scenarios:
- the actual byte values that flow through memory;
- the packed byte order;
- the row and column routing;
- that a pack sees a just-loaded pixel;
- that a move sees a filter write from the same cycle;
- that the pointer wraps at 2^16;
- that reserved codes are ignored.

// File: rtl/pix_lsu_pkg.sv
package pix_lsu_pkg;
    localparam int PIX_W  = 8;
    localparam int NPIX   = 4;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = $clog2(NPIX);
    localparam int WORD_W = PIX_W * NPIX;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDQ  = 3'd1,
        OP_STP  = 3'd2,
        OP_PACK = 3'd3,
        OP_SETA = 3'd4,
        OP_SETI = 3'd5,
        OP_MOVP = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    // memory-stage pipeline register
    typedef struct packed {
        logic  ld;
        logic  pk;
        logic  mv;
        logic  to_col;
        idx_t  idx;
        word_t word;
    } mstage_t;

    function automatic word_t pack_pix(input pix_t [NPIX-1:0] px);
        word_t w;
        for (int i = 0; i < NPIX; i++) begin
            w[i*PIX_W +: PIX_W] = px[i];
        end
        return w;
    endfunction
endpackage

// File: rtl/pix_addr_unit.sv
module pix_addr_unit
    import pix_lsu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_addr,
    input  logic  set_inc,
    input  logic  step,
    input  addr_t imm,
    output addr_t addr
);
    addr_t inc_q;
    addr_t addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            inc_q  <= '0;
        end else begin
            if (set_inc)
                inc_q <= imm;
            if (set_addr)
                addr_q <= imm;
            else if (step)
                addr_q <= addr_q + inc_q;
        end
    end

    assign addr = addr_q;

    // R4: each access moves the pointer by exactly the stride
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !set_addr) |=> (addr_q == $past(addr_q + inc_q)))
        else $error("pointer step mismatch");

    // R4: without access or set-address the pointer stays
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!step && !set_addr) |=> $stable(addr_q))
        else $error("pointer moved without access");

    // R5: stride changes only through set-increment
    p_inc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !set_inc |=> $stable(inc_q))
        else $error("stride changed");
endmodule

// File: rtl/pix_byte_file.sv
module pix_byte_file
    import pix_lsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  idx_t             widx,
    input  pix_t             wdata,
    output pix_t [NPIX-1:0]  cur,
    output pix_t [NPIX-1:0]  nxt
);
    for (genvar i = 0; i < NPIX; i++) begin : g_ent
        pix_t ent;
        logic hit;
        assign hit = we && (widx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                ent <= '0;
            else if (hit)
                ent <= wdata;
        end
        assign cur[i] = ent;
        assign nxt[i] = hit ? wdata : ent;
    end
endmodule

// File: rtl/pix_word_file.sv
module pix_word_file
    import pix_lsu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  widx,
    input  word_t wdata,
    input  idx_t  ridx,
    output word_t rdata
);
    word_t [NPIX-1:0] ents;

    for (genvar i = 0; i < NPIX; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ents[i] <= '0;
            else if (we && (widx == IDX_W'(i)))
                ents[i] <= wdata;
        end
    end

    assign rdata = ents[ridx];
endmodule

// File: rtl/pix_lsu_top.sv
module pix_lsu_top
    import pix_lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic [1:0]  op_idx,
    input  logic        op_dst_col,
    input  logic [15:0] op_imm,
    input  logic        p_wr_en,
    input  logic [1:0]  p_wr_idx,
    input  logic [7:0]  p_wr_data,
    output logic [15:0] mem_addr,
    output logic        mem_re,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        move_valid,
    output logic [7:0]  move_data,
    input  logic [1:0]  row_rd_idx,
    output logic [31:0] row_rd_data,
    input  logic [1:0]  col_rd_idx,
    output logic [31:0] col_rd_data
);
    op_e     op;
    logic    is_ld, is_st, is_pk, is_sa, is_si, is_mv;
    addr_t   addr;
    mstage_t ms_d, ms_q;
    pix_t [NPIX-1:0] q_cur, q_nxt, p_cur, p_nxt;
    logic    row_we, col_we;

    // decode stage
    always_comb begin
        op    = op_e'(op_code);
        is_ld = op_valid && (op == OP_LDQ);
        is_st = op_valid && (op == OP_STP);
        is_pk = op_valid && (op == OP_PACK);
        is_sa = op_valid && (op == OP_SETA);
        is_si = op_valid && (op == OP_SETI);
        is_mv = op_valid && (op == OP_MOVP);
    end

    pix_addr_unit u_addr (
        .clk      (clk),
        .rst      (rst),
        .set_addr (is_sa),
        .set_inc  (is_si),
        .step     (is_ld || is_st),
        .imm      (op_imm),
        .addr     (addr)
    );

    assign mem_addr  = addr;
    assign mem_re    = is_ld;
    assign mem_we    = is_st;
    assign mem_wdata = p_cur[op_idx];

    // Q file: written by load return in the memory stage
    pix_byte_file u_qfile (
        .clk   (clk),
        .rst   (rst),
        .we    (ms_q.ld),
        .widx  (ms_q.idx),
        .wdata (mem_rdata),
        .cur   (q_cur),
        .nxt   (q_nxt)
    );

    // P file: written by the filter
    pix_byte_file u_pfile (
        .clk   (clk),
        .rst   (rst),
        .we    (p_wr_en),
        .widx  (p_wr_idx),
        .wdata (p_wr_data),
        .cur   (p_cur),
        .nxt   (p_nxt)
    );

    always_comb begin
        ms_d.ld     = is_ld;
        ms_d.pk     = is_pk;
        ms_d.mv     = is_mv;
        ms_d.to_col = op_dst_col;
        ms_d.idx    = op_idx;
        ms_d.word   = pack_pix(q_nxt);  // snapshot includes in-flight load
    end

    always_ff @(posedge clk) begin
        if (rst)
            ms_q <= '0;
        else
            ms_q <= ms_d;
    end

    // memory stage
    assign row_we = ms_q.pk && !ms_q.to_col;
    assign col_we = ms_q.pk &&  ms_q.to_col;

    pix_word_file u_row (
        .clk   (clk),
        .rst   (rst),
        .we    (row_we),
        .widx  (ms_q.idx),
        .wdata (ms_q.word),
        .ridx  (row_rd_idx),
        .rdata (row_rd_data)
    );

    pix_word_file u_col (
        .clk   (clk),
        .rst   (rst),
        .we    (col_we),
        .widx  (ms_q.idx),
        .wdata (ms_q.word),
        .ridx  (col_rd_idx),
        .rdata (col_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            move_valid <= 1'b0;
            move_data  <= '0;
        end else begin
            move_valid <= ms_q.mv;
            move_data  <= p_nxt[ms_q.idx];  // late read sees same-cycle filter write
        end
    end

    // R10: one memory direction per cycle
    p_one_dir_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_re, mem_we}))
        else $error("read and write together");

    // R2: an issued load writes back in the following stage
    p_load_wb_r2: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> ms_q.ld)
        else $error("load lost");

    // R7: a pack lands in exactly one word file
    p_pack_route_r7: assert property (@(posedge clk) disable iff (rst)
        is_pk |=> (row_we ^ col_we))
        else $error("pack routing");

    // R9: a move in the memory stage yields a result next cycle
    p_move_lat_r9: assert property (@(posedge clk) disable iff (rst)
        ms_q.mv |=> move_valid)
        else $error("move result missing");
endmodule

// File: tb/sim_pix_lsu_top.sv
module sim_pix_lsu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_idx = '0;
    logic        op_dst_col = 1'b0;
    logic [15:0] op_imm = '0;
    logic        p_wr_en = 1'b0;
    logic [1:0]  p_wr_idx = '0;
    logic [7:0]  p_wr_data = '0;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        move_valid;
    logic [7:0]  move_data;
    logic [1:0]  row_rd_idx = '0;
    logic [31:0] row_rd_data;
    logic [1:0]  col_rd_idx = '0;
    logic [31:0] col_rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_lsu_top u0 (.*);

    // bench pixel memory, low 8 address bits
    logic [7:0] bmem [256];
    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
    end

    // reference model
    logic [7:0]  mdl_mem [256];
    logic [15:0] m_addr = '0, m_inc = '0;
    logic [7:0]  m_q [4];
    logic [7:0]  m_p [4];
    logic [31:0] m_row [4];
    logic [31:0] m_col [4];
    logic        prev_mv = 1'b0;
    logic [1:0]  prev_idx = '0;

    typedef struct { logic we; logic [15:0] a; logic [7:0] d; } acc_t;
    acc_t       mem_exp [$];
    logic [7:0] mv_exp [$];

    int n_chk = 0, n_bad = 0;
    logic started = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic issue(input int op, input int idx = 0, input bit col = 0,
                         input int imm = 0, input bit pwe = 0,
                         input int pidx = 0, input int pdata = 0);
        @(posedge clk); #1;
        op_valid   = 1'b1;
        op_code    = 3'(op);
        op_idx     = 2'(idx);
        op_dst_col = col;
        op_imm     = 16'(imm);
        p_wr_en    = pwe;
        p_wr_idx   = 2'(pidx);
        p_wr_data  = 8'(pdata);
        if (pwe) m_p[pidx] = 8'(pdata);
        if (prev_mv) mv_exp.push_back(m_p[prev_idx]);
        prev_mv  = (op == 6);
        prev_idx = 2'(idx);
        case (op)
            1: begin
                mem_exp.push_back('{1'b0, m_addr, 8'h00});
                m_q[idx] = mdl_mem[m_addr[7:0]];
                m_addr   = m_addr + m_inc;
            end
            2: begin
                mem_exp.push_back('{1'b1, m_addr, m_p[idx]});
                mdl_mem[m_addr[7:0]] = m_p[idx];
                m_addr = m_addr + m_inc;
            end
            3: begin
                if (col) m_col[idx] = {m_q[3], m_q[2], m_q[1], m_q[0]};
                else     m_row[idx] = {m_q[3], m_q[2], m_q[1], m_q[0]};
            end
            4: m_addr = 16'(imm);
            5: m_inc  = 16'(imm);
            default: ;
        endcase
    endtask

    task automatic chk_word(input bit col, input int idx, input string tag);
        @(negedge clk);
        row_rd_idx = 2'(idx);
        col_rd_idx = 2'(idx);
        #1;
        if (col) chk(tag, col_rd_data, m_col[idx]);
        else     chk(tag, row_rd_data, m_row[idx]);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (started) begin
            if (mem_re || mem_we) begin
                if (mem_exp.size() == 0) begin
                    chk("R11 unexpected access", {mem_re, mem_we}, 32'h0);
                end else begin
                    acc_t e;
                    e = mem_exp.pop_front();
                    chk(e.we ? "R3 R4 store addr" : "R2 R4 load addr", mem_addr, e.a);
                    chk("R10 direction", {mem_re, mem_we}, e.we ? 32'h1 : 32'h2);
                    if (e.we) chk("R3 store data", mem_wdata, e.d);
                end
            end
            if (move_valid) begin
                if (mv_exp.size() == 0)
                    chk("R9 unexpected move", 32'h1, 32'h0);
                else
                    chk("R9 move data", move_data, mv_exp.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i]    = 8'(i * 7 + 3);
            mdl_mem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 4; i++) begin
            m_q[i] = '0; m_p[i] = '0; m_row[i] = '0; m_col[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 mem_re", mem_re, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 move_valid", move_valid, 0);
        for (int i = 0; i < 4; i++) begin
            chk_word(0, i, "R1 row zero");
            chk_word(1, i, "R1 col zero");
        end
        started = 1'b1;

        // R1: P zero, stride zero keeps pointer at 0
        issue(6, 3);
        issue(1, 0);
        issue(1, 1);

        // R5 R6: stride 1 from 0x10, back-to-back loads (R10)
        issue(5, 0, 0, 1);
        issue(4, 0, 0, 'h10);
        for (int i = 0; i < 4; i++) issue(1, i);
        issue(3, 1, 0);               // R8: pack right after load, to row
        issue(7, 0, 0, 'h99);         // R11: reserved code
        issue(0);                     // R11: none
        @(posedge clk); #1 op_valid = 1'b0; op_code = 3'd1;  // R11: op_valid low
        issue(1, 2);                  // R4: pointer only stepped by loads
        issue(0); issue(0);
        chk_word(0, 1, "R7 R8 row pack");
        chk_word(1, 1, "R7 col untouched");

        // R12: filter writes P
        for (int i = 0; i < 4; i++) issue(0, 0, 0, 0, 1, i, 'hA0 + i);
        // R5: stride 16, stores at 0x40..0x70
        issue(5, 0, 0, 16);
        issue(4, 0, 0, 'h40);
        for (int i = 0; i < 4; i++) issue(2, i);
        issue(4, 0, 0, 'h40);
        for (int i = 0; i < 4; i++) issue(1, i);
        issue(3, 2, 1);               // R7 to column
        issue(0); issue(0);
        chk_word(1, 2, "R3 R7 col pack of stored pixels");
        chk_word(0, 2, "R7 row untouched");

        // R4: wrap modulo 2^16
        issue(5, 0, 0, 'h20);
        issue(4, 0, 0, 'hFFF0);
        issue(2, 1);
        issue(2, 2);
        issue(1, 0);

        // R9: move with same-cycle filter write
        issue(6, 2);
        issue(0, 0, 0, 0, 1, 2, 'h5C);
        issue(6, 1);
        issue(6, 0);
        issue(6, 3, 0, 0, 1, 3, 'h77);
        issue(0);
        issue(0); issue(0); issue(0);
        @(posedge clk); #1 op_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 R3 R9 all expected events seen", mem_exp.size() + mv_exp.size(), 0);
        summary();
    end
endmodule